// File: doc/BRIEF.md
# Priority-Nested Interrupt Acceptance Controller

This block decides, on every clock, whether a pending interrupt request may preempt the code that is currently running. There is no global enable or disable bit. Masking comes only from the current execution priority. A request carries a 6-bit level that was attached to it when it was delivered. The request is taken only when that level is strictly above the current priority. When a request is taken, the interrupted priority is saved on a small stack and the current priority becomes the request's level. Handlers therefore start re-entrant: anything more urgent can still nest on top of them.

Software can rewrite the current priority in one command. This includes raising it to level 63, which is kept for exclusive use by software: a device request that claims level 63 is demoted to 62, so it can never reach that level. A return pulse pops the saved level and restores it exactly, whatever software set inside the handler. A return pulse with nothing saved falls back to level 0 and flags an error for one cycle. Dispatch of the handler and queuing of the requests are done elsewhere. A refused request simply stays at the input until it is taken.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After a synchronous active-high reset, cur_prio is 0, req_accept is 0, ret_err is 0, and no saved levels are held.
- R2: A request is refused (req_accept stays 0 and cur_prio is unchanged by it) when its effective level is equal to or below the priority it is compared against.
- R3: A request whose effective level is strictly higher than the compared priority is taken at the next clock edge. req_accept is 1 for that one cycle, cur_prio equals the effective level, and the compared priority is pushed.
- R4: A request at level 63 has an effective level of 62. It is refused while the compared priority is 62 or 63, and when taken it sets cur_prio to 62, never 63.
- R5: A set-priority command with no return in the same cycle replaces the priority at the next edge with setp_level. Any value from 0 to 63 is allowed. At 63, every request is refused.
- R6: A return pulse restores the most recently pushed level, even if the priority was changed by set-priority inside the handler. Nested returns unwind in last-in, first-out order.
- R7: The stack holds 8 saved levels. A request that would need a ninth entry is refused even if its level is higher, and it is taken once a return frees an entry.
- R8: A return pulse with no saved levels sets the priority to 0 and drives ret_err to 1 for exactly the following cycle.
- R9: Within one cycle, a return is applied first, and a set-priority command in the same cycle is ignored. Without a return, the set-priority value is applied before the request comparison. The request is compared against the resulting priority, and the stack entry freed by the return is available to that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_prio | input | 6 | Level attached to the request at delivery |
| ret_pulse | input | 1 | Handler return: restore the saved level |
| setp_valid | input | 1 | Software command to rewrite the current priority |
| setp_level | input | 6 | New priority for the set command |
| req_accept | output | 1 | One-cycle pulse: the request of the previous cycle was taken |
| cur_prio | output | 6 | Current execution priority |
| ret_err | output | 1 | One-cycle pulse: a return arrived with no saved level |

## Verification
The stack and the priority register are the only state in this block, and both show up at the ports within a cycle or two. A wrong priority register changes which requests are taken on the very next request at the boundary level, and it appears on cur_prio one cycle after the edge. A corrupted, lost or misordered stack entry stays hidden until the matching return, so the bench unwinds nested handlers fully and checks every restored level. A wrong occupancy count shows up as a wrong refusal at the ninth nesting, or as a missing or spurious ret_err on the return that empties the stack.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int PRIO_W  = 6;
    localparam int TOP_LVL = (1 << PRIO_W) - 1;
    localparam int DEV_MAX = TOP_LVL - 1;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef struct packed {
        logic  valid;
        prio_t level;
    } prio_cmd_t;

    typedef struct packed {
        prio_t base;
        logic  pop;
        logic  err;
        logic  take;
        prio_t next;
    } gate_out_t;

    // devices may never claim the software-exclusive level
    function automatic prio_t dev_clamp(prio_t lvl);
        return (lvl == prio_t'(TOP_LVL)) ? prio_t'(DEV_MAX) : lvl;
    endfunction

endpackage

// File: rtl/prio_save_stack.sv
module prio_save_stack
    import irq_nest_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  prio_t                      push_data,
    input  logic                       pop,
    output prio_t                      top_data,
    output logic                       empty,
    output logic                       full
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    prio_t            mem [DEPTH];
    logic [CNT_W-1:0] count_q;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [CNT_W-1:0] wr_full;
    logic [CNT_W-1:0] rd_full;

    assign wr_full  = count_q - CNT_W'(pop);
    assign rd_full  = count_q - CNT_W'(1);
    assign wr_idx   = IDX_W'(wr_full);
    assign rd_idx   = IDX_W'(rd_full);
    assign empty    = (count_q == '0);
    assign full     = (count_q == CNT_W'(DEPTH));
    assign top_data = empty ? '0 : mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && push) begin
            mem[wr_idx] <= push_data;
        end
    end

    // R7: the stack is never written past its last entry
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> !full);

    // R8: an empty stack is never popped
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/prio_gate.sv
module prio_gate
    import irq_nest_pkg::*;
(
    input  prio_t     cur_prio,
    input  logic      ret_pulse,
    input  prio_cmd_t set_cmd,
    input  prio_cmd_t req_cmd,
    input  prio_t     saved_top,
    input  logic      stk_empty,
    input  logic      stk_full,
    output gate_out_t gate
);
    prio_t req_eff;
    logic  room;

    always_comb begin
        gate = '0;
        // step 1: the return is applied first, then the set command
        if (ret_pulse) begin
            if (stk_empty) begin
                gate.base = '0;
                gate.err  = 1'b1;
            end else begin
                gate.base = saved_top;
                gate.pop  = 1'b1;
            end
        end else if (set_cmd.valid) begin
            gate.base = set_cmd.level;
        end else begin
            gate.base = cur_prio;
        end
        // step 2: compare the request against the resulting priority
        req_eff   = dev_clamp(req_cmd.level);
        room      = !stk_full || gate.pop;
        gate.take = req_cmd.valid && (req_eff > gate.base) && room;
        gate.next = gate.take ? req_eff : gate.base;
    end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int STACK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic              ret_pulse,
    input  logic              setp_valid,
    input  logic [PRIO_W-1:0] setp_level,
    output logic              req_accept,
    output logic [PRIO_W-1:0] cur_prio,
    output logic              ret_err
);
    prio_t     cur_q;
    logic      acc_q;
    logic      err_q;
    prio_t     saved_top;
    logic      stk_empty;
    logic      stk_full;
    gate_out_t gate;
    prio_cmd_t set_cmd;
    prio_cmd_t req_cmd;

    assign set_cmd = '{valid: setp_valid, level: setp_level};
    assign req_cmd = '{valid: req_valid,  level: req_prio};

    prio_gate u_gate (
        .cur_prio  (cur_q),
        .ret_pulse (ret_pulse),
        .set_cmd   (set_cmd),
        .req_cmd   (req_cmd),
        .saved_top (saved_top),
        .stk_empty (stk_empty),
        .stk_full  (stk_full),
        .gate      (gate)
    );

    prio_save_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (gate.take),
        .push_data (gate.base),
        .pop       (gate.pop),
        .top_data  (saved_top),
        .empty     (stk_empty),
        .full      (stk_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            acc_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            cur_q <= gate.next;
            acc_q <= gate.take;
            err_q <= gate.err;
        end
    end

    assign cur_prio   = cur_q;
    assign req_accept = acc_q;
    assign ret_err    = err_q;

    // R2: a request not above the current level, with no return or set, is refused
    a_r2_refuse_not_higher: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !ret_pulse && !setp_valid && (dev_clamp(req_prio) <= cur_prio))
        |=> !req_accept);

    // R3: an accept pulse always follows a presented request
    a_r3_accept_from_req: assert property (@(posedge clk) disable iff (rst)
        req_accept |-> $past(req_valid));

    // R4: a taken request never lands at the exclusive level
    a_r4_never_exclusive: assert property (@(posedge clk) disable iff (rst)
        req_accept |-> (cur_prio != prio_t'(TOP_LVL)));

    // R5: a set without a return lands unless a request was taken over it
    a_r5_set_lands: assert property (@(posedge clk) disable iff (rst)
        (setp_valid && !ret_pulse) |=> (req_accept || (cur_prio == $past(setp_level))));

    // R8: an empty return leaves level 0 unless a request was taken in the same cycle
    a_r8_err_zero: assert property (@(posedge clk) disable iff (rst)
        (ret_err && !req_accept) |-> (cur_prio == '0));

endmodule

// File: tb/irq_nest_ctrl_tb_top.sv
module irq_nest_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid, ret_pulse, setp_valid;
    logic [5:0] req_prio, setp_level;
    logic       req_accept, ret_err;
    logic [5:0] cur_prio;

    int compared   = 0;
    int mismatched = 0;

    // reference model state
    int m_stack[$];
    int m_cur;
    bit m_acc, m_err;

    always #10 clk = ~clk; // 50 MHz

    irq_nest_ctrl dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_prio   (req_prio),
        .ret_pulse  (ret_pulse),
        .setp_valid (setp_valid),
        .setp_level (setp_level),
        .req_accept (req_accept),
        .cur_prio   (cur_prio),
        .ret_err    (ret_err)
    );

    task automatic compare(string tag);
        compared++;
        if (cur_prio !== 6'(m_cur)) begin
            mismatched++;
            $display("FAIL %s cur_prio actual=%0d expected=%0d", tag, cur_prio, m_cur);
        end
        compared++;
        if (req_accept !== m_acc) begin
            mismatched++;
            $display("FAIL %s req_accept actual=%0b expected=%0b", tag, req_accept, m_acc);
        end
        compared++;
        if (ret_err !== m_err) begin
            mismatched++;
            $display("FAIL %s ret_err actual=%0b expected=%0b", tag, ret_err, m_err);
        end
    endtask

    // one cycle: drive after a falling edge, advance the model, check after the rising edge
    task automatic step(bit rv, int rp, bit rt, bit sv, int sl, string tag);
        int p, e;
        req_valid  = rv;
        req_prio   = 6'(rp);
        ret_pulse  = rt;
        setp_valid = sv;
        setp_level = 6'(sl);
        m_err = 1'b0;
        if (rt) begin
            if (m_stack.size() > 0) p = m_stack.pop_back();
            else begin p = 0; m_err = 1'b1; end
        end else if (sv) p = sl;
        else p = m_cur;
        e = (rp == 63) ? 62 : rp;
        m_acc = rv && (e > p) && (m_stack.size() < 8);
        if (m_acc) begin
            m_stack.push_back(p);
            m_cur = e;
        end else m_cur = p;
        @(posedge clk);
        #5;
        compare(tag);
        @(negedge clk);
    endtask

    task automatic req(int lvl, string tag);  step(1, lvl, 0, 0, 0, tag); endtask
    task automatic ret(string tag);           step(0, 0, 1, 0, 0, tag); endtask
    task automatic setp(int lvl, string tag); step(0, 0, 0, 1, lvl, tag); endtask
    task automatic idle(string tag);          step(0, 0, 0, 0, 0, tag); endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 0; req_prio = 0; ret_pulse = 0; setp_valid = 0; setp_level = 0;
        m_cur = 0; m_acc = 0; m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R1 reset");
        idle("R1 idle after reset");

        // R2 / R3: strict comparison and entry
        req(5, "R3 take 5 over 0");
        req(5, "R2 equal refused");
        req(3, "R2 lower refused");
        req(9, "R3 nest 9 over 5");
        // R6: change inside handler, return restores saved level
        setp(40, "R5 set inside handler");
        ret("R6 restore 5");
        ret("R6 restore 0");

        // R4: device clamp
        setp(62, "R5 set 62");
        req(63, "R4 63 refused at 62");
        setp(61, "R5 set 61");
        req(63, "R4 63 taken as 62");
        req(63, "R4 63 refused when at 62");
        ret("R6 restore 61");

        // R5: exclusive level blocks everything
        setp(63, "R5 set exclusive");
        req(62, "R5 62 refused at 63");
        req(63, "R5 63 refused at 63");
        setp(0, "R5 back to 0");

        // R7: fill eight entries, ninth refused, retried after a return
        for (int i = 1; i <= 8; i++) req(i * 2, "R7 fill");
        req(30, "R7 ninth refused when full");
        req(30, "R7 still refused");
        ret("R6 unwind one");
        req(30, "R7 retry taken after return");
        for (int i = 0; i < 8; i++) ret("R6 unwind lifo");
        // R8: empty return
        ret("R8 empty return");
        idle("R8 err lasts one cycle");
        setp(12, "R5 set 12");
        ret("R8 empty return clears to 0");

        // R9: same-cycle orderings
        req(10, "R9 setup take 10");
        step(1, 5, 1, 0, 0, "R9 return then accept 5");
        step(0, 0, 1, 1, 40, "R9 set ignored with return");
        step(1, 20, 0, 1, 30, "R9 set before compare refuses 20");
        step(1, 35, 0, 1, 30, "R9 set before compare takes 35");
        for (int i = 1; i <= 7; i++) req(35 + i, "R7 refill");
        step(1, 60, 1, 0, 0, "R9 freed entry usable same cycle");
        for (int i = 0; i < 9; i++) ret("R8 drain to error");

        // mixed random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(1, 0) == 1, $urandom_range(63, 0),
                 $urandom_range(5, 0) == 0, $urandom_range(7, 0) == 0,
                 $urandom_range(63, 0), "R2 R6 R7 random mix");
        end

        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_stack.delete(); m_cur = 0; m_acc = 0; m_err = 0;
        compare("R1 reset mid-run");
        ret("R1 stack cleared by reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule